// File: doc/BRIEF.md
# Linear Charger Phase Controller

This block sequences the charge cycle of a single lithium cell behind a linear charger. It does not see voltages or currents. It sees only the digital outputs of analog comparators: input supply level and overvoltage, battery level against the precondition, regulation and recharge points, charge current against the end-of-charge level, and die over-temperature. It also reads the charge-inhibit and continuous-charge pins and the expiry flags of an external safety timer. From these it selects a charge phase, drives the charge switch enable, picks the system-rail regulation target, and sends a pulse that restarts the safety timer.

Every asynchronous flag passes through a two-flop synchronizer. Phase changes that analog ripple could cause without reason are qualified by consecutive-cycle counters. These cover trickle and fast transitions in both directions, end-of-charge and recharge. A timer expiry before completion locks the controller in a fault phase. Only loss of input power releases it. A continuous-charge pin set high keeps the cell in constant-voltage charge past end-of-charge and past timer expiry.

Top module: `chg_phase_ctrl`

## Requirements
- R1: After reset, and before any charge start, phase_o is OFF (code 0), chg_sw_en_o is 0 and tmr_clr_o is 0.
- R2: Input power is good only when vin_por_i=1, vin_over_bat_i=1 and vin_ovp_i=0. With power not good the phase is OFF. Loss of good power moves any phase to OFF on the third rising clock edge after the change, and also clears a fault.
- R3: From OFF or SUSPENDED (code 6), with power good, no over-temperature and no inhibit, charging starts on the third edge. It enters TRICKLE (code 1) when bat_precond_i=1 and FAST (code 2) otherwise. tmr_clr_o is high for exactly the one cycle in which the new phase first shows.
- R4: TRICKLE moves to FAST once bat_precond_i has been 0 for DG_PHASE_CYC consecutive synchronized cycles. FAST moves to TRICKLE once it has been 1 for DG_PHASE_CYC consecutive cycles. A shorter excursion has no effect.
- R5: FAST moves to CV (code 3) on the third edge after bat_at_reg_i rises.
- R6: In CV with cont_chg_i=0, ichg_eoc_i held for DG_PHASE_CYC consecutive synchronized cycles moves the phase to COMPLETE (code 4) with the charge switch off.
- R7: With cont_chg_i=0, tmr_pre_exp_i in TRICKLE, or tmr_fast_exp_i in FAST or CV, moves the phase to FAULT (code 5) on the third edge.
- R8: FAULT holds while power stays good, even under over-temperature or inhibit.
- R9: In COMPLETE, bat_rch_i held for DG_RCH_CYC consecutive synchronized cycles starts a recharge in FAST and pulses tmr_clr_o.
- R10: die_hot_i=1 moves any phase except FAULT to OFF on the third edge. Charging restarts per R3 once the flag clears.
- R11: chg_inhibit_i=1 moves any phase except FAULT to SUSPENDED with the switch off. Releasing it restarts charging per R3.
- R12: rail_track_o follows bat_above_sys_i with a two-edge latency in every phase. 1 selects battery-plus-offset tracking and 0 selects the fixed rail level.
- R13: chg_sw_en_o is 1 exactly in TRICKLE, FAST and CV.
- R14: With cont_chg_i=1, CV neither completes on end-of-charge nor faults on timer expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| vin_por_i | input | 1 | Input above power-on level |
| vin_over_bat_i | input | 1 | Input above battery plus offset |
| vin_ovp_i | input | 1 | Input above overvoltage threshold |
| bat_precond_i | input | 1 | Battery below precondition level |
| bat_at_reg_i | input | 1 | Battery at regulation level |
| bat_rch_i | input | 1 | Battery below recharge level |
| ichg_eoc_i | input | 1 | Charge current below end-of-charge level |
| die_hot_i | input | 1 | Die over-temperature (comparator carries hysteresis) |
| chg_inhibit_i | input | 1 | Charge disable pin, active high |
| cont_chg_i | input | 1 | Continuous-charge override |
| tmr_pre_exp_i | input | 1 | Trickle safety timer expired |
| tmr_fast_exp_i | input | 1 | Fast safety timer expired |
| bat_above_sys_i | input | 1 | Battery above system-rail crossover level |
| phase_o | output | 3 | Charge phase code |
| chg_sw_en_o | output | 1 | Charge switch enable |
| rail_track_o | output | 1 | System-rail target select |
| tmr_clr_o | output | 1 | Safety timer restart pulse |

## Verification
The checker watches the global rules on every cycle. These are the drop to OFF on power loss or over-temperature, the fault latch, the move to SUSPENDED under inhibit, CV holding under the continuous-charge override, the switch being off in COMPLETE, and timer restarts happening only while charging. Only the directed scenarios can show the exact counts. These are how many consecutive cycles a deglitch window needs, that a shorter excursion is discarded, which phase a start chooses, and the two-edge rail-select latency.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    PH_OFF     = 3'd0,
    PH_TRICKLE = 3'd1,
    PH_FAST    = 3'd2,
    PH_CV      = 3'd3,
    PH_DONE    = 3'd4,
    PH_FAULT   = 3'd5,
    PH_SUSP    = 3'd6
  } chg_phase_e;

  // bit positions inside the synchronized flag vector
  localparam int unsigned IX_POR   = 0;
  localparam int unsigned IX_GTB   = 1;
  localparam int unsigned IX_OVP   = 2;
  localparam int unsigned IX_PRE   = 3;
  localparam int unsigned IX_REG   = 4;
  localparam int unsigned IX_RCH   = 5;
  localparam int unsigned IX_EOC   = 6;
  localparam int unsigned IX_HOT   = 7;
  localparam int unsigned IX_INH   = 8;
  localparam int unsigned IX_CONT  = 9;
  localparam int unsigned IX_TPRE  = 10;
  localparam int unsigned IX_TFAST = 11;
  localparam int unsigned IX_B32   = 12;
  localparam int unsigned N_FLAGS  = 13;

  function automatic logic f_power_good(input logic por, input logic gtb, input logic ovp);
    return por & gtb & ~ovp;
  endfunction

  function automatic logic f_charging(input chg_phase_e ph);
    return (ph == PH_TRICKLE) || (ph == PH_FAST) || (ph == PH_CV);
  endfunction

endpackage

// File: rtl/chg_sync_bank.sv
module chg_sync_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= d_i[gi];
          stab_q <= meta_q;
        end
      end
      assign q_o[gi] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/chg_deglitch.sv
module chg_deglitch #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  output logic qual_o
);

  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!cond_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // high on the LEN-th consecutive cycle of cond_i
  assign qual_o = cond_i && (cnt_q == LAST);

endmodule

// File: rtl/chg_phase_fsm.sv
module chg_phase_fsm
  import chg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pg_i,
  input  logic       hot_i,
  input  logic       inh_i,
  input  logic       cont_i,
  input  logic       pre_i,
  input  logic       reg_i,
  input  logic       tpre_i,
  input  logic       tfast_i,
  input  logic       q_up_i,
  input  logic       q_dn_i,
  input  logic       q_eoc_i,
  input  logic       q_rch_i,
  output chg_phase_e phase_o,
  output logic       tmr_clr_o
);

  chg_phase_e state_q, state_d;
  logic       clr_q, clr_d;

  always_comb begin
    state_d = state_q;
    clr_d   = 1'b0;
    if (!pg_i) begin
      state_d = PH_OFF;
    end else if (state_q == PH_FAULT) begin
      state_d = PH_FAULT;
    end else if (hot_i) begin
      state_d = PH_OFF;
    end else if (inh_i) begin
      state_d = PH_SUSP;
    end else begin
      unique case (state_q)
        PH_OFF, PH_SUSP: begin
          state_d = pre_i ? PH_TRICKLE : PH_FAST;
          clr_d   = 1'b1;
        end
        PH_TRICKLE: begin
          if (tpre_i && !cont_i)   state_d = PH_FAULT;
          else if (q_up_i)         state_d = PH_FAST;
        end
        PH_FAST: begin
          if (tfast_i && !cont_i)  state_d = PH_FAULT;
          else if (reg_i)          state_d = PH_CV;
          else if (q_dn_i)         state_d = PH_TRICKLE;
        end
        PH_CV: begin
          if (tfast_i && !cont_i)     state_d = PH_FAULT;
          else if (q_eoc_i && !cont_i) state_d = PH_DONE;
        end
        PH_DONE: begin
          if (q_rch_i) begin
            state_d = PH_FAST;
            clr_d   = 1'b1;
          end
        end
        default: state_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_OFF;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
    end
  end

  assign phase_o   = state_q;
  assign tmr_clr_o = clr_q;

endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl
  import chg_pkg::*;
#(
  parameter int unsigned DG_PHASE_CYC = 25000,
  parameter int unsigned DG_RCH_CYC   = 300000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vin_por_i,
  input  logic       vin_over_bat_i,
  input  logic       vin_ovp_i,
  input  logic       bat_precond_i,
  input  logic       bat_at_reg_i,
  input  logic       bat_rch_i,
  input  logic       ichg_eoc_i,
  input  logic       die_hot_i,
  input  logic       chg_inhibit_i,
  input  logic       cont_chg_i,
  input  logic       tmr_pre_exp_i,
  input  logic       tmr_fast_exp_i,
  input  logic       bat_above_sys_i,
  output logic [2:0] phase_o,
  output logic       chg_sw_en_o,
  output logic       rail_track_o,
  output logic       tmr_clr_o
);

  logic [N_FLAGS-1:0] raw_vec, s_vec;

  always_comb begin
    raw_vec           = '0;
    raw_vec[IX_POR]   = vin_por_i;
    raw_vec[IX_GTB]   = vin_over_bat_i;
    raw_vec[IX_OVP]   = vin_ovp_i;
    raw_vec[IX_PRE]   = bat_precond_i;
    raw_vec[IX_REG]   = bat_at_reg_i;
    raw_vec[IX_RCH]   = bat_rch_i;
    raw_vec[IX_EOC]   = ichg_eoc_i;
    raw_vec[IX_HOT]   = die_hot_i;
    raw_vec[IX_INH]   = chg_inhibit_i;
    raw_vec[IX_CONT]  = cont_chg_i;
    raw_vec[IX_TPRE]  = tmr_pre_exp_i;
    raw_vec[IX_TFAST] = tmr_fast_exp_i;
    raw_vec[IX_B32]   = bat_above_sys_i;
  end

  chg_sync_bank #(.W(N_FLAGS)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_vec),
    .q_o  (s_vec)
  );

  // named internal events, visible to the bound checker
  chg_phase_e phase_q;
  logic pg_s, hot_s, inh_s, cont_s;
  logic c_up, c_dn, c_eoc, c_rch;
  logic q_up, q_dn, q_eoc, q_rch;

  assign pg_s   = f_power_good(s_vec[IX_POR], s_vec[IX_GTB], s_vec[IX_OVP]);
  assign hot_s  = s_vec[IX_HOT];
  assign inh_s  = s_vec[IX_INH];
  assign cont_s = s_vec[IX_CONT];

  assign c_up  = (phase_q == PH_TRICKLE) && !s_vec[IX_PRE];
  assign c_dn  = (phase_q == PH_FAST)    &&  s_vec[IX_PRE];
  assign c_eoc = (phase_q == PH_CV)      &&  s_vec[IX_EOC];
  assign c_rch = (phase_q == PH_DONE)    &&  s_vec[IX_RCH];

  chg_deglitch #(.LEN(DG_PHASE_CYC)) dg_up_i  (.clk(clk), .rst_n(rst_n), .cond_i(c_up),  .qual_o(q_up));
  chg_deglitch #(.LEN(DG_PHASE_CYC)) dg_dn_i  (.clk(clk), .rst_n(rst_n), .cond_i(c_dn),  .qual_o(q_dn));
  chg_deglitch #(.LEN(DG_PHASE_CYC)) dg_eoc_i (.clk(clk), .rst_n(rst_n), .cond_i(c_eoc), .qual_o(q_eoc));
  chg_deglitch #(.LEN(DG_RCH_CYC))   dg_rch_i (.clk(clk), .rst_n(rst_n), .cond_i(c_rch), .qual_o(q_rch));

  chg_phase_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_i     (pg_s),
    .hot_i    (hot_s),
    .inh_i    (inh_s),
    .cont_i   (cont_s),
    .pre_i    (s_vec[IX_PRE]),
    .reg_i    (s_vec[IX_REG]),
    .tpre_i   (s_vec[IX_TPRE]),
    .tfast_i  (s_vec[IX_TFAST]),
    .q_up_i   (q_up),
    .q_dn_i   (q_dn),
    .q_eoc_i  (q_eoc),
    .q_rch_i  (q_rch),
    .phase_o  (phase_q),
    .tmr_clr_o(tmr_clr_o)
  );

  assign phase_o      = phase_q;
  assign chg_sw_en_o  = f_charging(phase_q);
  assign rail_track_o = s_vec[IX_B32];

endmodule

// File: rtl/chg_phase_chk.sv
module chg_phase_chk
  import chg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] phase,
  input logic       sw_en,
  input logic       pg,
  input logic       hot,
  input logic       inh,
  input logic       cont,
  input logic       tmr_clr
);

  // R2
  pwr_loss_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pg |=> phase == PH_OFF);

  // R10
  hot_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hot && phase != PH_FAULT |=> phase == PH_OFF);

  // R8
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FAULT && pg |=> phase == PH_FAULT);

  // R11
  inhibit_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inh && pg && !hot && phase != PH_FAULT |=> phase == PH_SUSP);

  // R14
  cont_holds_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cont && pg && !hot && !inh && phase == PH_CV |=> phase == PH_CV);

  // R6
  done_switch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_DONE |-> !sw_en);

  // R3
  clr_only_charging_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> sw_en && $changed(phase));

endmodule

bind chg_phase_ctrl chg_phase_chk chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .phase  (phase_o),
  .sw_en  (chg_sw_en_o),
  .pg     (pg_s),
  .hot    (hot_s),
  .inh    (inh_s),
  .cont   (cont_s),
  .tmr_clr(tmr_clr_o)
);

// File: tb/chg_phase_ctrl_tb.sv
module chg_phase_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int DG    = 6;
  localparam int RCH   = 15;

  localparam logic [2:0] OFF = 3'd0, TRK = 3'd1, FST = 3'd2, CV = 3'd3,
                         DONE = 3'd4, FLT = 3'd5, SUSP = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por = 0, gtb = 0, ovp = 0, pre = 0, regl = 0, rch = 0, eoc = 0;
  logic hot = 0, inh = 0, cont = 0, tpre = 0, tfast = 0, b32 = 0;
  logic [2:0] phase;
  logic sw_en, rail, tclr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  chg_phase_ctrl #(.DG_PHASE_CYC(DG), .DG_RCH_CYC(RCH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .vin_por_i(por), .vin_over_bat_i(gtb), .vin_ovp_i(ovp),
    .bat_precond_i(pre), .bat_at_reg_i(regl), .bat_rch_i(rch),
    .ichg_eoc_i(eoc), .die_hot_i(hot), .chg_inhibit_i(inh),
    .cont_chg_i(cont), .tmr_pre_exp_i(tpre), .tmr_fast_exp_i(tfast),
    .bat_above_sys_i(b32),
    .phase_o(phase), .chg_sw_en_o(sw_en), .rail_track_o(rail), .tmr_clr_o(tclr)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic power_down();
    por = 0; gtb = 0; ovp = 0; pre = 0; regl = 0; rch = 0; eoc = 0;
    hot = 0; inh = 0; cont = 0; tpre = 0; tfast = 0;
    step(4);
  endtask

  task automatic power_up(input logic low_bat, input logic [2:0] exp_ph);
    pre = low_bat; por = 1; gtb = 1; ovp = 0;
    step(2);
    chk("R3 wait", phase, OFF);
    step(1);
    chk("R3 start phase", phase, exp_ph);
    chk("R3 timer clear", tclr, 1);
    chk("R13 switch", sw_en, 1);
    step(1);
    chk("R3 clear one cycle", tclr, 0);
  endtask

  task automatic t_reset();
    chk("R1 phase", phase, OFF);
    chk("R1 switch", sw_en, 0);
    chk("R1 tclr", tclr, 0);
  endtask

  task automatic t_power_window();
    por = 1; gtb = 0; step(5);
    chk("R2 no offset", phase, OFF);
    gtb = 1; ovp = 1; step(5);
    chk("R2 overvoltage", phase, OFF);
    chk("R13 off switch", sw_en, 0);
    ovp = 0;
    power_up(1'b1, TRK);
    ovp = 1; step(2);
    chk("R2 ovp delay", phase, TRK);
    step(1);
    chk("R2 ovp drop", phase, OFF);
    power_down();
  endtask

  task automatic t_trickle_fast();
    power_up(1'b1, TRK);
    pre = 0; step(3); pre = 1; step(DG + 4);
    chk("R4 glitch ignored", phase, TRK);
    pre = 0; step(1 + DG);
    chk("R4 up not yet", phase, TRK);
    step(1);
    chk("R4 up", phase, FST);
    pre = 1; step(1 + DG);
    chk("R4 down not yet", phase, FST);
    step(1);
    chk("R4 down", phase, TRK);
    power_down();
  endtask

  task automatic t_cv_done_recharge();
    power_up(1'b0, FST);
    regl = 1; step(2);
    chk("R5 wait", phase, FST);
    step(1);
    chk("R5 cv", phase, CV);
    eoc = 1; step(1 + DG);
    chk("R6 not yet", phase, CV);
    step(1);
    chk("R6 done", phase, DONE);
    chk("R6 switch off", sw_en, 0);
    eoc = 0; regl = 0; rch = 1;
    step(1 + RCH);
    chk("R9 not yet", phase, DONE);
    step(1);
    chk("R9 recharge", phase, FST);
    chk("R9 timer clear", tclr, 1);
    rch = 0;
    power_down();
  endtask

  task automatic t_cont_fault();
    cont = 1;
    power_up(1'b0, FST);
    regl = 1; step(3);
    chk("R5 cv", phase, CV);
    eoc = 1; step(DG + 10);
    chk("R14 no completion", phase, CV);
    tfast = 1; step(5);
    chk("R14 no fault", phase, CV);
    cont = 0; step(3);
    chk("R7 fast fault", phase, FLT);
    chk("R13 fault switch", sw_en, 0);
    hot = 1; step(5);
    chk("R8 hot held", phase, FLT);
    inh = 1; step(5);
    chk("R8 inhibit held", phase, FLT);
    por = 0; step(3);
    chk("R2 clears fault", phase, OFF);
    power_down();
  endtask

  task automatic t_trickle_timeout();
    power_up(1'b1, TRK);
    tpre = 1; step(2);
    chk("R7 wait", phase, TRK);
    step(1);
    chk("R7 pre fault", phase, FLT);
    power_down();
  endtask

  task automatic t_hot();
    power_up(1'b0, FST);
    hot = 1; step(2);
    chk("R10 wait", phase, FST);
    step(1);
    chk("R10 off", phase, OFF);
    chk("R10 switch", sw_en, 0);
    hot = 0; step(3);
    chk("R10 restart", phase, FST);
    chk("R10 tclr", tclr, 1);
    power_down();
  endtask

  task automatic t_inhibit();
    power_up(1'b0, FST);
    inh = 1; step(3);
    chk("R11 suspend", phase, SUSP);
    chk("R11 switch", sw_en, 0);
    inh = 0; step(3);
    chk("R11 resume", phase, FST);
    power_down();
  endtask

  task automatic t_rail();
    b32 = 1; step(1);
    chk("R12 latency", rail, 0);
    step(1);
    chk("R12 track", rail, 1);
    b32 = 0; step(2);
    chk("R12 fixed", rail, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_power_window();
    t_trickle_fast();
    t_cv_done_recharge();
    t_cont_fault();
    t_trickle_timeout();
    t_hot();
    t_inhibit();
    t_rail();
    summary();
  end

endmodule